// File: doc/BRIEF.md
# Pixel Configuration Memory Writer

This block loads a configuration word into every pixel of a two-dimensional sensor array. An external controller supplies a configuration clock, an enable, a synchronous active-low reset and a 10-bit word. The writer steps through the pixels in row-major order and spends two clocks on each one. In the first clock it presents the address and captures the word. In the second clock it raises a write strobe. After the last pixel it raises a one-cycle done flag and stops. It starts again only after a reset, or after the enable is taken low and then high again.

Each pixel stores its word in a behavioural register model. The model decodes the word into four gain-capacitor switches, an amplifier enable, and a stimulus routing that picks one of three shared excitation lines. A pixel whose amplifier enable goes from 0 to 1 on a write drives its feedback-reset switch for a fixed number of clocks. This lets the slow high-pass pole settle. A combinational read port brings out any pixel's stored word, its decoded fields and its switch state, so that the array can be checked from outside. With the default 32 × 32 array a full pass takes 2048 clocks.

Top module: `pixel_cfg_writer`

## Requirements
- R1: While reset is low at a clock edge, the address returns to row 0, column 0, the write strobe and done are low, and every pixel word and feedback-reset switch is cleared.
- R2: With enable high, each pixel takes two clocks. The edge that ends the first clock captures `cfg_word`. The strobe is high for the whole second clock. The strobe is never high in two consecutive clocks.
- R3: Pixels are visited row-major. The column advances after each strobe. After the last column, the row advances and the column returns to 0.
- R4: While enable is low, the address and the phase within the pixel are held and the strobe stays low. Raising enable again resumes at the same pixel and phase.
- R5: In the clock after the strobe for the last pixel, done is high for exactly one cycle and the address reads row 0, column 0. The writer then stays idle, with no strobe, until enable goes low and then high again.
- R6: A strobe stores the captured word into the addressed pixel. The read port returns the stored word of the pixel selected by `rd_row`/`rd_col`.
- R7: Word bits [3:0] are the gain code. Bit i closes gain capacitor switch i, and `rd_gain_sw` equals bits [3:0].
- R8: Bit 6 enables the amplifier. Bit 7 enables the stimulator. Bits [5:4] select the excitation line: code 0 selects line 0, code 1 selects line 1, code 2 selects line 2, and code 3 selects none. `rd_stim_route` is one-hot or zero, and it is zero whenever bit 7 is 0.
- R9: A write that changes a pixel's bit 6 from 0 to 1 closes its feedback-reset switch for SETTLE_CYC (default 4) clocks after the write edge. A write that leaves bit 6 at 1 does not close the switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Sequence enable; low pauses, a low-to-high edge restarts after done |
| cfg_word | input | 10 | Word for the currently addressed pixel |
| row_addr | output | 5 | Row of the current pixel |
| col_addr | output | 5 | Column of the current pixel |
| wr_data | output | 10 | Captured word being written |
| wr_strobe | output | 1 | Write strobe, high in the second clock of a pixel |
| done | output | 1 | One-cycle pulse after the last pixel is written |
| rd_row | input | 5 | Read port row select |
| rd_col | input | 5 | Read port column select |
| rd_word | output | 10 | Stored word of the selected pixel |
| rd_gain_sw | output | 4 | Gain capacitor switch states of the selected pixel |
| rd_amp_en | output | 1 | Amplifier enable of the selected pixel |
| rd_stim_route | output | 3 | One-hot excitation line selection of the selected pixel |
| rd_settle | output | 1 | Feedback-reset switch state of the selected pixel |

## Verification
The hardest case to reach is a feedback-reset pulse. It needs a pixel whose amplifier bit was already written as 0 and is then rewritten as 1. This happens only in a second full pass, after a done and an enable restart. The bench makes the first pass enable only the odd-numbered pixels and the second pass enable every pixel. It then watches for the strobe at one even pixel and samples its switch over the following five clocks. It also checks an odd pixel just after its rewrite, where no pulse may appear. The pause and the done pulse are reached by tracking the address outputs rather than by counting clocks.

// File: rtl/pcw_pkg.sv
// Shared field layout for the pixel configuration word.
// Assumes a 10-bit word; positions below are decoded by every pixel cell.
package pcw_pkg;
    localparam int WORD_W    = 10;
    localparam int GAIN_LSB  = 0;
    localparam int GAIN_W    = 4;
    localparam int STIM_LSB  = 4;
    localparam int AMP_BIT   = 6;
    localparam int STIM_EN   = 7;
    localparam int NUM_LINES = 3;

    // Map a 2-bit excitation code to a one-hot line select (code 3 selects none).
    function automatic logic [NUM_LINES-1:0] line_select(input logic [1:0] code);
        logic [NUM_LINES-1:0] sel;
        sel = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (code == 2'(i)) sel[i] = 1'b1;
        end
        return sel;
    endfunction
endpackage

// File: rtl/pcw_sequencer.sv
// Row-major address walker: two clocks per pixel (capture, then strobe).
// Assumes ROWS and COLS are both at least 2; reset is synchronous, active low.
module pcw_sequencer #(
    parameter int ROWS = 32,
    parameter int COLS = 32,
    parameter int W    = 10,
    localparam int RW  = $clog2(ROWS),
    localparam int CW  = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [W-1:0]  cfg_word,
    output logic [RW-1:0] row_o,
    output logic [CW-1:0] col_o,
    output logic [W-1:0]  data_o,
    output logic          strobe_o,
    output logic          done_o
);
    logic [RW-1:0] row_q;
    logic [CW-1:0] col_q;
    logic [W-1:0]  data_q;
    logic          phase_q, halt_q, en_q, done_q;
    logic          at_last, at_col_end;

    assign at_col_end = (col_q == CW'(COLS-1));
    assign at_last    = at_col_end && (row_q == RW'(ROWS-1));
    assign strobe_o   = en && phase_q && !halt_q;
    assign row_o      = row_q;
    assign col_o      = col_q;
    assign data_o     = data_q;
    assign done_o     = done_q;

    // Remember last enable level to spot a restart edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en;
    end

    // Step phase and address; halt after the last pixel until an enable edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            col_q   <= '0;
            data_q  <= '0;
            phase_q <= 1'b0;
            halt_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (halt_q) begin
                if (en && !en_q) halt_q <= 1'b0;
            end else if (en) begin
                if (!phase_q) begin
                    data_q  <= cfg_word;
                    phase_q <= 1'b1;
                end else begin
                    phase_q <= 1'b0;
                    if (at_last) begin
                        row_q  <= '0;
                        col_q  <= '0;
                        halt_q <= 1'b1;
                        done_q <= 1'b1;
                    end else if (at_col_end) begin
                        col_q <= '0;
                        row_q <= row_q + 1'b1;
                    end else begin
                        col_q <= col_q + 1'b1;
                    end
                end
            end
        end
    end

    // R2
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);
    // R4
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(row_q) && $stable(col_q) && $stable(phase_q)));
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R5
    done_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (row_q == '0 && col_q == '0 && !strobe_o));
endmodule

// File: rtl/pcw_pixel_cell.sv
// Behavioural model of one pixel's configuration register and settle switch.
// Assumes SETTLE_CYC >= 1; the switch closes on an amplifier 0->1 write.
module pcw_pixel_cell #(
    parameter int W          = 10,
    parameter int SETTLE_CYC = 4,
    localparam int SW        = $clog2(SETTLE_CYC + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wr_word,
    output logic [W-1:0] word_o,
    output logic         settle_o
);
    import pcw_pkg::*;

    logic [W-1:0]  word_q;
    logic [SW-1:0] cnt_q;
    logic          turn_on;

    assign turn_on  = we && !word_q[AMP_BIT] && wr_word[AMP_BIT];
    assign word_o   = word_q;
    assign settle_o = (cnt_q != '0);

    // Store the word on a strobe addressed to this pixel.
    always_ff @(posedge clk) begin
        if (!rst_n)  word_q <= '0;
        else if (we) word_q <= wr_word;
    end

    // Load the settle window on amplifier turn-on, otherwise count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (turn_on)        cnt_q <= SW'(SETTLE_CYC);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    // R9
    settle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !word_q[AMP_BIT] && wr_word[AMP_BIT]) |=> (cnt_q == SW'(SETTLE_CYC)));
    // R9
    settle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= SW'(SETTLE_CYC));
endmodule

// File: rtl/pixel_cfg_writer.sv
// Top: sequencer driving a generated grid of pixel cells, plus a read port.
// Assumes ROWS, COLS >= 2; read selects outside the grid return zero.
module pixel_cfg_writer #(
    parameter int ROWS       = 32,
    parameter int COLS       = 32,
    parameter int SETTLE_CYC = 4,
    localparam int W         = pcw_pkg::WORD_W,
    localparam int RW        = $clog2(ROWS),
    localparam int CW        = $clog2(COLS),
    localparam int NPIX      = ROWS * COLS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [W-1:0]  cfg_word,
    output logic [RW-1:0] row_addr,
    output logic [CW-1:0] col_addr,
    output logic [W-1:0]  wr_data,
    output logic          wr_strobe,
    output logic          done,
    input  logic [RW-1:0] rd_row,
    input  logic [CW-1:0] rd_col,
    output logic [W-1:0]  rd_word,
    output logic [3:0]    rd_gain_sw,
    output logic          rd_amp_en,
    output logic [2:0]    rd_stim_route,
    output logic          rd_settle
);
    import pcw_pkg::*;

    logic [W-1:0] words  [NPIX];
    logic         settles[NPIX];

    pcw_sequencer #(.ROWS(ROWS), .COLS(COLS), .W(W)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_word(cfg_word),
        .row_o(row_addr), .col_o(col_addr), .data_o(wr_data),
        .strobe_o(wr_strobe), .done_o(done)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            logic hit;
            assign hit = wr_strobe && (row_addr == RW'(r)) && (col_addr == CW'(c));
            pcw_pixel_cell #(.W(W), .SETTLE_CYC(SETTLE_CYC)) u_cell (
                .clk(clk), .rst_n(rst_n), .we(hit), .wr_word(wr_data),
                .word_o(words[r*COLS+c]), .settle_o(settles[r*COLS+c])
            );
        end
    end

    // Select the read pixel and decode its fields.
    always_comb begin
        rd_word   = '0;
        rd_settle = 1'b0;
        if (int'(rd_row) < ROWS && int'(rd_col) < COLS) begin
            rd_word   = words[int'(rd_row) * COLS + int'(rd_col)];
            rd_settle = settles[int'(rd_row) * COLS + int'(rd_col)];
        end
        rd_gain_sw    = rd_word[GAIN_LSB +: GAIN_W];
        rd_amp_en     = rd_word[AMP_BIT];
        rd_stim_route = rd_word[STIM_EN] ? line_select(rd_word[STIM_LSB +: 2]) : '0;
    end

    // R8
    route_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_stim_route));
endmodule

// File: tb/pixel_cfg_writer_test.sv
module pixel_cfg_writer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [9:0] cfg_word = '0;
    logic [4:0] row_addr, col_addr, rd_row = '0, rd_col = '0;
    logic [9:0] wr_data, rd_word;
    logic       wr_strobe, done, rd_amp_en, rd_settle;
    logic [3:0] rd_gain_sw;
    logic [2:0] rd_stim_route;
    int checks = 0, fails = 0, pass_no = 1;

    always #4 clk = ~clk;

    pixel_cfg_writer uut (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_word(cfg_word),
        .row_addr(row_addr), .col_addr(col_addr), .wr_data(wr_data),
        .wr_strobe(wr_strobe), .done(done), .rd_row(rd_row), .rd_col(rd_col),
        .rd_word(rd_word), .rd_gain_sw(rd_gain_sw), .rd_amp_en(rd_amp_en),
        .rd_stim_route(rd_stim_route), .rd_settle(rd_settle)
    );

    function automatic logic [9:0] word_for(int pass, int p);
        logic [9:0] base;
        logic amp;
        base = 10'((p * 37 + 5) ^ (p >> 3));
        amp  = (pass == 1) ? p[0] : 1'b1;
        return {base[9:7], amp, base[5:0]};
    endfunction

    function automatic logic [2:0] route_for(logic [9:0] w);
        if (!w[7]) return 3'b000;
        case (w[5:4])
            2'd0: return 3'b001;
            2'd1: return 3'b010;
            2'd2: return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    // Present the word for whatever pixel the writer addresses.
    always @(negedge clk) cfg_word = word_for(pass_no, int'(row_addr) * 32 + int'(col_addr));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_strobe_at(input int r, input int c);
        do @(negedge clk); while (!(wr_strobe && row_addr == 5'(r) && col_addr == 5'(c)));
    endtask

    task automatic t_reset();
        @(negedge clk);
        rd_row = 5; rd_col = 7; #1;
        chk(row_addr == 0 && col_addr == 0, "R1 addr", {row_addr, col_addr}, 0);
        chk(!wr_strobe && !done, "R1 strobe/done", {wr_strobe, done}, 0);
        chk(rd_word == 0 && !rd_settle, "R1 pixel clear", {rd_word, rd_settle}, 0);
    endtask

    task automatic t_timing();
        en = 1'b1;
        @(negedge clk);
        chk(wr_strobe && row_addr == 0 && col_addr == 0, "R2 strobe 2nd clock", {wr_strobe, row_addr, col_addr}, 32'h400);
        chk(wr_data == word_for(1, 0), "R2 captured word", wr_data, word_for(1, 0));
        @(negedge clk);
        chk(!wr_strobe && col_addr == 1, "R3 col advance", {wr_strobe, col_addr}, 1);
        @(negedge clk);
        chk(wr_strobe, "R2 strobe pixel 1", wr_strobe, 1);
        wait_strobe_at(0, 31);
        @(negedge clk);
        chk(row_addr == 1 && col_addr == 0, "R3 row wrap", {row_addr, col_addr}, 32'h20);
    endtask

    task automatic t_pause();
        logic [4:0] r0, c0;
        wait_strobe_at(2, 9);
        en = 1'b0; r0 = row_addr; c0 = col_addr; #1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!wr_strobe && row_addr == r0 && col_addr == c0, "R4 hold", {wr_strobe, row_addr, col_addr}, {1'b0, r0, c0});
        end
        en = 1'b1; #1;
        chk(wr_strobe && row_addr == r0 && col_addr == c0, "R4 resume", {wr_strobe, row_addr, col_addr}, {1'b1, r0, c0});
    endtask

    task automatic t_pass_end();
        wait_strobe_at(31, 31);
        @(negedge clk);
        chk(done && row_addr == 0 && col_addr == 0 && !wr_strobe, "R5 done", {done, row_addr, col_addr, wr_strobe}, 32'h800);
        @(negedge clk);
        chk(!done, "R5 done one cycle", done, 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!wr_strobe && row_addr == 0 && col_addr == 0, "R5 idle", {wr_strobe, row_addr, col_addr}, 0);
        end
    endtask

    task automatic t_readback();
        for (int p = 0; p < 1024; p++) begin
            logic [9:0] w;
            w = word_for(1, p);
            rd_row = 5'(p / 32); rd_col = 5'(p % 32); #1;
            chk(rd_word == w, "R6 readback", rd_word, w);
            chk(rd_gain_sw == w[3:0], "R7 gain switches", rd_gain_sw, w[3:0]);
            chk(rd_amp_en == w[6] && rd_stim_route == route_for(w), "R8 decode", {rd_amp_en, rd_stim_route}, {w[6], route_for(w)});
        end
    endtask

    task automatic t_settle();
        pass_no = 2;
        @(negedge clk); en = 1'b0;
        @(negedge clk); en = 1'b1;
        rd_row = 0; rd_col = 20;
        wait_strobe_at(0, 20);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(rd_settle, "R9 settle window", rd_settle, 1);
        end
        @(negedge clk);
        chk(!rd_settle, "R9 settle ends", rd_settle, 0);
        rd_row = 1; rd_col = 9;
        wait_strobe_at(1, 9);
        @(negedge clk);
        chk(!rd_settle && rd_amp_en, "R9 no pulse when already on", {rd_settle, rd_amp_en}, 1);
    endtask

    task automatic t_reset_mid();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_row = 0; rd_col = 20; #1;
        chk(rd_word == 0 && row_addr == 0 && col_addr == 0 && !done, "R1 mid-pass reset", {rd_word, row_addr, col_addr, done}, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_timing();
        t_pause();
        t_pass_end();
        t_readback();
        t_settle();
        t_reset_mid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule